// File: doc/BRIEF.md
# Floating-Point Register Stack

This block holds the eight 80-bit working registers of a floating-point unit. The registers are addressed through a rotating 3-bit top pointer, not by physical index. Software-visible register ST(i) lives in physical slot (TOP + i) mod 8. Loads enter at the top of the stack and stores leave from it. A read can name any ST(i). An arithmetic unit outside the block gets the two operands ST and ST(idx) on combinational ports. It returns its result on a separate input, which the stack writes back either in place or with a pop.

Each physical slot carries a tag bit that marks it full or empty. Pushing onto an occupied slot raises a stack-overflow pulse. Using an empty slot raises a stack-underflow pulse. In both cases nothing inside the block changes. The top pointer and the tag vector are exported so that a status word and a tag word can be built outside.

A controller state machine tracks how full the stack is. It has three states:
- OCC_EMPTY: no slot in use.
- OCC_PARTIAL: one to seven slots in use.
- OCC_FULL: all eight slots in use.

Its transitions are:
- OCC_EMPTY to OCC_PARTIAL on any successful push.
- OCC_PARTIAL to OCC_FULL on a push that fills the eighth slot.
- OCC_PARTIAL to OCC_EMPTY on a pop that frees the last slot.
- OCC_FULL to OCC_PARTIAL on any successful pop.
- Every other case holds the state.

A push issued in OCC_FULL is the overflow case.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset, top_ptr is 0, slot_full is all zero, and stk_overflow, stk_underflow and rd_valid are low.
- R2: A push (op_code 1) first decrements TOP modulo 8, then writes ld_data into the new ST and sets that slot's bit in slot_full. slot_full bit n belongs to physical slot n, and ST(i) is physical slot (TOP + i) mod 8.
- R3: A push whose target slot is already full pulses stk_overflow for one cycle. It leaves TOP, the tags and the stored data unchanged.
- R4: A pop (op_code 2) on a full ST presents that value on rd_data with rd_valid high for one cycle. It also clears the slot's tag and increments TOP modulo 8.
- R5: A pop or read of an empty slot pulses stk_underflow for one cycle. rd_valid stays low, and TOP and the tags are unchanged.
- R6: A read (op_code 3) presents ST(st_idx) on rd_data with rd_valid high. It leaves TOP and the tags unchanged.
- R7: opa_data always shows ST and opb_data always shows ST(st_idx), combinationally from the current inputs and state.
- R8: Register mode (op_code 4) writes res_data into ST(st_idx) and leaves TOP unchanged. If ST or ST(st_idx) is empty, it pulses stk_underflow instead and writes nothing.
- R9: Operate-with-pop mode (op_code 5) writes res_data into ST(st_idx), clears the old ST and increments TOP, all in the same clock. With st_idx equal to 1, the result becomes the new ST. If either operand is empty, it pulses stk_underflow and changes nothing.
- R10: TOP wraps: a push at TOP 0 goes to 7, and a pop at TOP 7 goes to 0.
- R11: With op_valid low, or with op_code 0, 6 or 7, nothing changes and no output flag pulses.
- R12: stk_overflow, stk_underflow and rd_valid are registered and appear in the cycle after the edge that accepts the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | 0 none, 1 push, 2 pop, 3 read, 4 register op, 5 op with pop |
| st_idx | input | 3 | Stack-relative index i for ST(i) |
| ld_data | input | 80 | Value to push |
| res_data | input | 80 | Result from the external arithmetic unit |
| opa_data | output | 80 | Current ST |
| opb_data | output | 80 | Current ST(st_idx) |
| rd_data | output | 80 | Popped or read value |
| rd_valid | output | 1 | rd_data is valid this cycle |
| stk_overflow | output | 1 | Push onto a full slot |
| stk_underflow | output | 1 | Access to an empty slot |
| top_ptr | output | 3 | Current top pointer |
| slot_full | output | 8 | Per-physical-slot full tags |

## Verification
The bench fills all eight slots, so that TOP wraps from 0 to 7 on the way down. A design that got this wrong would land data in a slot that does not follow the modulo-8 mapping, or would miss the ninth-push overflow. It then pushes a ninth value and checks that the first stored value is still intact; a design that let a failed push write would corrupt it. The operate-with-pop case is checked by reading the new ST right afterwards. A design that applied the write and the pointer increment in separate cycles, or wrote ST instead of ST(1), would return a stale operand there. Finally, the bench drains the stack so that TOP wraps from 7 to 0, pops once more to force underflow, and sends an invalid strobe and unused op codes to confirm that they leave the state untouched.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_READ  = 3'd3,
        OP_OPREG = 3'd4,
        OP_OPPOP = 3'd5
    } stk_op_e;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    typedef enum logic {
        WSEL_LOAD   = 1'b0,
        WSEL_RESULT = 1'b1
    } wsel_e;

endpackage

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
    parameter int WIDTH = 80,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             clr_en,
    input  logic [PTR_W-1:0] clr_ptr,
    input  logic [PTR_W-1:0] ra_ptr,
    input  logic [PTR_W-1:0] rb_ptr,
    output logic [WIDTH-1:0] ra_data,
    output logic [WIDTH-1:0] rb_data,
    output logic [DEPTH-1:0] full_vec
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0] tag_q;

    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            if (wr_en && wr_ptr == PTR_W'(s)) begin
                mem_q[s] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                if (clr_en && clr_ptr == PTR_W'(s)) begin
                    tag_q[s] <= 1'b0;
                end else if (wr_en && wr_ptr == PTR_W'(s)) begin
                    tag_q[s] <= 1'b1;
                end
            end
        end
    end

    assign ra_data  = mem_q[ra_ptr];
    assign rb_data  = mem_q[rb_ptr];
    assign full_vec = tag_q;

    // R4: a freed slot reads as empty on the next cycle
    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !full_vec[$past(clr_ptr)]);

    // R2: a written slot, not freed at the same edge, reads as full
    assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(clr_en && clr_ptr == wr_ptr)) |=> full_vec[$past(wr_ptr)]);

endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
    import fpstk_pkg::*;
#(
    parameter int WIDTH = 80,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [PTR_W-1:0] st_idx,
    input  logic [WIDTH-1:0] ld_data,
    input  logic [WIDTH-1:0] res_data,
    input  logic [DEPTH-1:0] full_vec,
    input  logic [WIDTH-1:0] ra_data,
    input  logic [WIDTH-1:0] rb_data,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [WIDTH-1:0] wr_data,
    output logic             clr_en,
    output logic [PTR_W-1:0] clr_ptr,
    output logic [PTR_W-1:0] ra_ptr,
    output logic [PTR_W-1:0] rb_ptr,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             stk_overflow,
    output logic             stk_underflow,
    output logic [PTR_W-1:0] top_ptr
);

    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

    occ_state_e       occ_q, occ_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] top_q, top_d;
    logic [PTR_W-1:0] push_ptr;
    logic             a_full, b_full;
    logic             push_ok, pop_ok;
    logic             ovf_d, unf_d, rdv_d;
    logic             rd_from_b;
    wsel_e            wsel;
    logic [WIDTH-1:0] rd_q;
    logic             ovf_q, unf_q, rdv_q;

    assign ra_ptr   = top_q;
    assign rb_ptr   = top_q + st_idx;
    assign push_ptr = top_q - PTR_ONE;
    assign a_full   = full_vec[ra_ptr];
    assign b_full   = full_vec[rb_ptr];
    assign wr_data  = (wsel == WSEL_RESULT) ? res_data : ld_data;

    // State register for the occupancy machine and its counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= OCC_EMPTY;
            cnt_q <= '0;
            top_q <= '0;
        end else begin
            occ_q <= occ_d;
            cnt_q <= cnt_d;
            top_q <= top_d;
        end
    end

    // Next-state logic of the occupancy machine
    always_comb begin
        occ_d = occ_q;
        cnt_d = cnt_q;
        if (push_ok) begin
            cnt_d = cnt_q + CNT_ONE;
        end else if (pop_ok) begin
            cnt_d = cnt_q - CNT_ONE;
        end
        unique case (occ_q)
            OCC_EMPTY: begin
                if (push_ok) occ_d = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (push_ok && cnt_q == CNT_LAST) occ_d = OCC_FULL;
                else if (pop_ok && cnt_q == CNT_ONE) occ_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (pop_ok) occ_d = OCC_PARTIAL;
            end
            default: occ_d = OCC_EMPTY;
        endcase
    end

    // Operation decode: write, free and pointer actions plus flags
    always_comb begin
        wr_en     = 1'b0;
        wr_ptr    = rb_ptr;
        wsel      = WSEL_RESULT;
        clr_en    = 1'b0;
        clr_ptr   = ra_ptr;
        top_d     = top_q;
        push_ok   = 1'b0;
        pop_ok    = 1'b0;
        ovf_d     = 1'b0;
        unf_d     = 1'b0;
        rdv_d     = 1'b0;
        rd_from_b = 1'b0;
        if (op_valid) begin
            unique case (op_code)
                OP_PUSH: begin
                    if (occ_q == OCC_FULL) begin
                        ovf_d = 1'b1;
                    end else begin
                        wr_en   = 1'b1;
                        wr_ptr  = push_ptr;
                        wsel    = WSEL_LOAD;
                        top_d   = push_ptr;
                        push_ok = 1'b1;
                    end
                end
                OP_POP: begin
                    if (!a_full) begin
                        unf_d = 1'b1;
                    end else begin
                        rdv_d  = 1'b1;
                        clr_en = 1'b1;
                        top_d  = top_q + PTR_ONE;
                        pop_ok = 1'b1;
                    end
                end
                OP_READ: begin
                    if (!b_full) begin
                        unf_d = 1'b1;
                    end else begin
                        rdv_d     = 1'b1;
                        rd_from_b = 1'b1;
                    end
                end
                OP_OPREG: begin
                    if (!(a_full && b_full)) begin
                        unf_d = 1'b1;
                    end else begin
                        wr_en = 1'b1;
                    end
                end
                OP_OPPOP: begin
                    if (!(a_full && b_full)) begin
                        unf_d = 1'b1;
                    end else begin
                        wr_en  = 1'b1;
                        clr_en = 1'b1;
                        top_d  = top_q + PTR_ONE;
                        pop_ok = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            rdv_q <= 1'b0;
            rd_q  <= '0;
        end else begin
            ovf_q <= ovf_d;
            unf_q <= unf_d;
            rdv_q <= rdv_d;
            if (rdv_d) rd_q <= rd_from_b ? rb_data : ra_data;
        end
    end

    assign rd_data       = rd_q;
    assign rd_valid      = rdv_q;
    assign stk_overflow  = ovf_q;
    assign stk_underflow = unf_q;
    assign top_ptr       = top_q;

    // R3: the full state agrees with the tag vector
    assert_full_state_tags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_FULL) |-> (&full_vec));

    // R1: the empty state agrees with the tag vector
    assert_empty_state_tags_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_EMPTY) |-> (full_vec == '0));

    // R3: a push onto a free slot never overflows
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_PUSH && !full_vec[top_q - PTR_ONE]) |=> !stk_overflow);

    // R2: a push either overflows or moves TOP down by one
    assert_push_moves_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_PUSH) |=>
            (stk_overflow || top_ptr == $past(top_ptr) - PTR_ONE));

    // R9: op-with-pop either underflows or moves TOP up by one
    assert_oppop_moves_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_OPPOP) |=>
            (stk_underflow || top_ptr == $past(top_ptr) + PTR_ONE));

    // R5: an underflow leaves TOP where it was
    assert_underflow_holds_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stk_underflow |-> $stable(top_ptr));

    // R12: at most one result flag per operation
    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stk_overflow, stk_underflow, rd_valid}));

    // R11: no strobe, no flag on the next cycle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !(stk_overflow || stk_underflow || rd_valid));

endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack #(
    parameter int WIDTH = 80,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [PTR_W-1:0] st_idx,
    input  logic [WIDTH-1:0] ld_data,
    input  logic [WIDTH-1:0] res_data,
    output logic [WIDTH-1:0] opa_data,
    output logic [WIDTH-1:0] opb_data,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             stk_overflow,
    output logic             stk_underflow,
    output logic [PTR_W-1:0] top_ptr,
    output logic [DEPTH-1:0] slot_full
);

    logic             wr_en, clr_en;
    logic [PTR_W-1:0] wr_ptr, clr_ptr, ra_ptr, rb_ptr;
    logic [WIDTH-1:0] wr_data, ra_data, rb_data;
    logic [DEPTH-1:0] full_vec;

    fpstk_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_code       (op_code),
        .st_idx        (st_idx),
        .ld_data       (ld_data),
        .res_data      (res_data),
        .full_vec      (full_vec),
        .ra_data       (ra_data),
        .rb_data       (rb_data),
        .wr_en         (wr_en),
        .wr_ptr        (wr_ptr),
        .wr_data       (wr_data),
        .clr_en        (clr_en),
        .clr_ptr       (clr_ptr),
        .ra_ptr        (ra_ptr),
        .rb_ptr        (rb_ptr),
        .rd_data       (rd_data),
        .rd_valid      (rd_valid),
        .stk_overflow  (stk_overflow),
        .stk_underflow (stk_underflow),
        .top_ptr       (top_ptr)
    );

    fpstk_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .wr_data  (wr_data),
        .clr_en   (clr_en),
        .clr_ptr  (clr_ptr),
        .ra_ptr   (ra_ptr),
        .rb_ptr   (rb_ptr),
        .ra_data  (ra_data),
        .rb_data  (rb_data),
        .full_vec (full_vec)
    );

    assign opa_data  = ra_data;
    assign opb_data  = rb_data;
    assign slot_full = full_vec;

endmodule

// File: tb/fp_reg_stack_bench.sv
module fp_reg_stack_bench;

    typedef struct {
        logic        rdv;
        logic [79:0] rdd;
        logic        ovf;
        logic        unf;
        logic [2:0]  top;
        logic [7:0]  tags;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [2:0]  st_idx = 3'd0;
    logic [79:0] ld_data = '0;
    logic [79:0] res_data = '0;
    logic [79:0] opa_data, opb_data, rd_data;
    logic        rd_valid, stk_overflow, stk_underflow;
    logic [2:0]  top_ptr;
    logic [7:0]  slot_full;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    logic [79:0] m_data [8];
    logic [7:0]  m_full = '0;
    logic [2:0]  m_top = '0;

    always #4 clk = ~clk;

    fp_reg_stack u_fp_reg_stack (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .st_idx(st_idx), .ld_data(ld_data), .res_data(res_data),
        .opa_data(opa_data), .opb_data(opb_data), .rd_data(rd_data),
        .rd_valid(rd_valid), .stk_overflow(stk_overflow),
        .stk_underflow(stk_underflow), .top_ptr(top_ptr), .slot_full(slot_full)
    );

    function automatic logic [79:0] val(input int k);
        return {16'h3F00 + 16'(k), 64'hC0DE_0000_0000_0000 | 64'(k)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: applies one operation and queues the expected outcome
    task automatic step(input bit vld, input logic [2:0] op, input int idx,
                        input logic [79:0] ld, input logic [79:0] res, input string req);
        exp_t e;
        logic [2:0] pa, pb, pp;
        @(negedge clk);
        op_valid = vld; op_code = op; st_idx = 3'(idx); ld_data = ld; res_data = res;
        #1;
        pa = m_top; pb = m_top + 3'(idx); pp = m_top - 3'd1;
        if (m_full[pa]) check(opa_data == m_data[pa], "R7", "opa_data", opa_data, m_data[pa]);
        if (m_full[pb]) check(opb_data == m_data[pb], "R7", "opb_data", opb_data, m_data[pb]);
        e.rdv = 0; e.rdd = '0; e.ovf = 0; e.unf = 0; e.req = req;
        if (vld) begin
            case (op)
                3'd1: if (m_full[pp]) e.ovf = 1;
                      else begin m_top = pp; m_data[pp] = ld; m_full[pp] = 1; end
                3'd2: if (!m_full[pa]) e.unf = 1;
                      else begin e.rdv = 1; e.rdd = m_data[pa]; m_full[pa] = 0; m_top = pa + 3'd1; end
                3'd3: if (!m_full[pb]) e.unf = 1;
                      else begin e.rdv = 1; e.rdd = m_data[pb]; end
                3'd4: if (!(m_full[pa] && m_full[pb])) e.unf = 1;
                      else m_data[pb] = res;
                3'd5: if (!(m_full[pa] && m_full[pb])) e.unf = 1;
                      else begin m_data[pb] = res; m_full[pa] = 0; m_top = pa + 3'd1; end
                default: ;
            endcase
        end
        e.top = m_top; e.tags = m_full;
        sb_q.push_back(e);
    endtask

    // Monitor: compares each queued expectation after the accepting edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                bit ok;
                e = sb_q.pop_front();
                ok = (top_ptr == e.top) && (slot_full == e.tags) && (stk_overflow == e.ovf)
                     && (stk_underflow == e.unf) && (rd_valid == e.rdv)
                     && (!e.rdv || rd_data == e.rdd);
                checks++;
                if (!ok) begin
                    errors++;
                    $display("FAIL %s: actual top=%0d tags=%b ovf=%b unf=%b rdv=%b rd=%h expected top=%0d tags=%b ovf=%b unf=%b rdv=%b rd=%h",
                             e.req, top_ptr, slot_full, stk_overflow, stk_underflow, rd_valid, rd_data,
                             e.top, e.tags, e.ovf, e.unf, e.rdv, e.rdd);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(top_ptr == 3'd0, "R1", "top_ptr", 80'(top_ptr), 80'd0);
        check(slot_full == 8'd0, "R1", "slot_full", 80'(slot_full), 80'd0);
        check({stk_overflow, stk_underflow, rd_valid} == 3'b000, "R1", "flags",
              80'({stk_overflow, stk_underflow, rd_valid}), 80'd0);
        // R5 pop and read on an empty stack
        step(1, 3'd2, 0, '0, '0, "R5_pop_empty");
        step(1, 3'd3, 2, '0, '0, "R5_read_empty");
        // R2, R10 fill all eight slots, TOP wraps 0 to 7
        for (int k = 1; k <= 8; k++) step(1, 3'd1, 0, val(k), '0, "R2_R10_push");
        // R3 ninth push overflows, first value intact
        step(1, 3'd1, 0, val(99), '0, "R3_overflow");
        step(1, 3'd3, 7, '0, '0, "R3_intact");
        // R6 read ST(3)
        step(1, 3'd3, 3, '0, '0, "R6_read");
        // R8 register mode into ST(2), then read back
        step(1, 3'd4, 2, '0, val(200), "R8_regop");
        step(1, 3'd3, 2, '0, '0, "R8_readback");
        // R9 operate with pop, result becomes new ST
        step(1, 3'd5, 1, '0, val(300), "R9_oppop");
        step(1, 3'd3, 0, '0, '0, "R9_new_top");
        // R11 invalid strobe and unused codes
        step(0, 3'd1, 0, val(400), '0, "R11_no_strobe");
        step(1, 3'd7, 0, val(401), val(402), "R11_code7");
        step(1, 3'd0, 0, val(403), '0, "R11_code0");
        // R4, R10 drain seven entries, TOP wraps 7 to 0
        for (int k = 0; k < 7; k++) step(1, 3'd2, 0, '0, '0, "R4_R10_pop");
        step(1, 3'd2, 0, '0, '0, "R5_pop_after_drain");
        // R9 underflow when ST(1) empty; R8 in place on ST
        step(1, 3'd1, 0, val(500), '0, "R2_push_single");
        step(1, 3'd5, 1, '0, val(501), "R9_underflow");
        step(1, 3'd4, 1, '0, val(502), "R8_underflow");
        step(1, 3'd4, 0, '0, val(503), "R8_in_place");
        step(1, 3'd2, 0, '0, '0, "R4_pop_last");
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R12", "pending", 80'(sb_q.size()), 80'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule